// File: doc/BRIEF.md
# Byte-Wide Serial Shift Engine with Mode Register

This block is the master side of a synchronous serial link. It moves one byte out and one byte in per frame. The host programs an 8-bit mode register through a write strobe. That register chooses four things: the order in which bits go out, the level the serial clock rests at, which clock edge launches data and which captures it, and how far the serial clock is divided down from the block clock. The host then pulses a start strobe together with the byte to send.

While the frame runs, the engine makes the serial clock by dividing its own clock. It drives data-out and samples data-in on the edges the mode selects. At the end it raises a one-cycle done pulse, and the received byte is valid in that cycle. The register setting is captured when the frame begins, so the host may reprogram the register while a frame is running without disturbing it. A start request that carries the reserved rate code is refused: the engine raises an error pulse and does not drive the clock.

Top module: `sser_engine`

## Requirements
- R1: The mode register resets to 0x00, and `mode_rd` shows it one cycle after a write. Bits 4:3 always read 0, and writing them has no effect. Field positions: bit 7 is order, bit 6 is polarity, bit 5 is phase, and bits 2:0 are the rate.
- R2: With rate code c (1..7), each half period of `sclk` lasts 2^c clock cycles, which is a division of 2^(c+1). A frame has 16 half periods, and `busy` is high for 16·2^c cycles.
- R3: When polarity is 0, `sclk` rests high and pulses low. When polarity is 1, it rests low and pulses high. While idle, `sclk` follows the register's polarity one cycle after a write.
- R4: When phase is 0, `sdo` takes the next bit on the first edge of each bit period, and `sdi` is captured on the second edge.
- R5: When phase is 1, the first bit appears on `sdo` in the cycle after start, before any clock edge. `sdi` is captured on the first edge of each bit period, and `sdo` advances on the second edge, except for the last one.
- R6: Order bit 1 sends and assembles most significant bit first. Order bit 0 sends and assembles least significant bit first.
- R7: A start request with rate code 000 raises `err` for one cycle. It sets no `busy` and leaves `sclk` at rest.
- R8: A start request while `busy` is high has no effect on the running frame.
- R9: Register writes made during a frame do not change that frame. They apply to the next frame.
- R10: On the final edge, `sclk` returns to rest, `busy` falls, and `done` is high for exactly one cycle. `rx_byte` holds the received byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| mode_rd | output | 8 | Mode register readback |
| start | input | 1 | Frame start request |
| tx_byte | input | 8 | Byte to send, taken with start |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | One-cycle pulse on start with reserved rate |
| rx_byte | output | 8 | Received byte |

## Verification
Every output is registered, so each response shows up on the clock edge after the cause. `mode_rd` and an idle `sclk` follow a write one cycle later. `busy`, `err` and the early data bit for phase 1 follow start one cycle later. Each `sclk` edge arrives 2^c cycles after the previous one. `done` and the final `rx_byte` appear together with the sixteenth edge. The bench runs a behavioural model on the same edges, built from queues and counters. It compares every output at the falling clock edge of every cycle, so no check falls between a cause and its due cycle. The received byte is compared only in the done cycle.

// File: rtl/sser_pkg.sv
package sser_pkg;
  typedef struct packed {
    logic       msb_first;
    logic       idle_low;
    logic       late_phase;
    logic [1:0] rsvd;
    logic [2:0] rate;
  } mode_t;
endpackage

// File: rtl/sser_modereg.sv
module sser_modereg
  import sser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output mode_t      mode_q
);
  mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      mode_d      = mode_t'(wr_data);
      mode_d.rsvd = 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/sser_prescale.sv
module sser_prescale #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = 2 ** RATE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_lim;

  always_comb begin
    half_lim = (CNT_W'(1) << rate) - CNT_W'(1);
    tick     = run && (cnt_q == half_lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sser_shifter.sv
module sser_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              late_ld,
  input  logic              msb_first,
  input  logic [DATA_W-1:0] tx,
  input  logic              drive,
  input  logic              sample,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rx
);
  logic [DATA_W-1:0] sr_q, sr_d, rx_d, src;
  logic              sdo_q, sdo_d;

  always_comb begin
    sr_d  = sr_q;
    sdo_d = sdo_q;
    rx_d  = rx;
    src   = load ? tx : sr_q;
    if ((load && late_ld) || (!load && drive)) begin
      sdo_d = msb_first ? src[DATA_W-1] : src[0];
      sr_d  = msb_first ? (src << 1) : (src >> 1);
    end else if (load) begin
      sr_d = tx;
    end
    if (sample)
      rx_d = msb_first ? {rx[DATA_W-2:0], sdi} : {sdi, rx[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
      rx    <= '0;
    end else begin
      sr_q  <= sr_d;
      sdo_q <= sdo_d;
      rx    <= rx_d;
    end
  end

  assign sdo = sdo_q;
endmodule

// File: rtl/sser_engine.sv
module sser_engine
  import sser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        mode_rd,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES + 1);

  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  mode_t          mode_q, act_q, act_d;
  logic           busy_q, busy_d, sclk_q, sclk_d, done_q, done_d, err_q, err_d;
  logic [EW-1:0]  edge_q, edge_d;
  logic           tick, start_ok, start_bad, first_edge, last_edge;
  logic           drive, sample, order;

  sser_modereg u_mode (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_data(wr_data), .mode_q(mode_q)
  );

  sser_prescale #(.RATE_W(3)) u_pre (
    .clk(clk), .rst_n(rst_i), .run(busy_q), .rate(act_q.rate), .tick(tick)
  );

  always_comb begin
    start_ok   = start && !busy_q && (mode_q.rate != 3'd0);
    start_bad  = start && !busy_q && (mode_q.rate == 3'd0);
    first_edge = ~edge_q[0];
    last_edge  = (edge_q == EW'(EDGES - 1));
    drive      = busy_q && tick && (act_q.late_phase ? (!first_edge && !last_edge) : first_edge);
    sample     = busy_q && tick && (act_q.late_phase ? first_edge : !first_edge);
    order      = busy_q ? act_q.msb_first : mode_q.msb_first;
  end

  always_comb begin
    busy_d = busy_q;
    edge_d = edge_q;
    sclk_d = sclk_q;
    act_d  = act_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (busy_q) begin
      if (tick) begin
        edge_d = edge_q + EW'(1);
        sclk_d = ~sclk_q;
        if (last_edge) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end else begin
      sclk_d = ~mode_q.idle_low;
      err_d  = start_bad;
      if (start_ok) begin
        busy_d = 1'b1;
        edge_d = '0;
        act_d  = mode_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sclk_q <= 1'b1;
      act_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      edge_q <= edge_d;
      sclk_q <= sclk_d;
      act_q  <= act_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  sser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_i), .load(start_ok), .late_ld(mode_q.late_phase),
    .msb_first(order), .tx(tx_byte), .drive(drive), .sample(sample),
    .sdi(sdi), .sdo(sdo), .rx(rx_byte)
  );

  assign mode_rd = mode_q;
  assign sclk    = sclk_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign err     = err_q;
endmodule

// File: rtl/sser_chk.sv
module sser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] mode_rd
);
  // R10
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $fell(busy));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) mode_rd[4:3] == 2'b00);
  // R7
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> !busy);
  // R7
  reject_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> !busy);
endmodule

bind sser_engine sser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .mode_rd(mode_rd)
);

// File: tb/sim_sser_engine.sv
module sim_sser_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       sdi = 1'b0;
  logic [7:0] mode_rd, rx_byte;
  logic       sclk, sdo, busy, done, err;

  always #4 clk = ~clk;

  sser_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode_rd(mode_rd),
    .start(start), .tx_byte(tx_byte), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .busy(busy), .done(done), .err(err), .rx_byte(rx_byte)
  );

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit running = 1'b1;

  // behavioural reference
  logic [7:0] m_mode = '0, m_act = '0, m_rx = '0;
  bit   m_busy = 0, m_done = 0, m_err = 0, m_sclk = 1, m_sdo = 0;
  int   m_cnt = 0, m_edge = 0;
  bit   q_tx[$];

  always @(posedge clk) begin
    bit ok, first, late;
    if (rst_n) begin
      ok = start && !m_busy && (m_mode[2:0] != 3'd0);
      m_done = 0;
      m_err  = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == (1 << m_act[2:0])) begin
          m_cnt = 0;
          m_edge++;
          m_sclk = !m_sclk;
          first = (m_edge % 2) == 1;
          late  = m_act[5];
          if ((!late && first) || (late && !first && m_edge != 16))
            m_sdo = q_tx.pop_front();
          if ((!late && !first) || (late && first)) begin
            if (m_act[7]) m_rx = {m_rx[6:0], sdi};
            else          m_rx = {sdi, m_rx[7:1]};
          end
          if (m_edge == 16) begin
            m_busy = 0;
            m_done = 1;
          end
        end
      end else begin
        m_sclk = !m_mode[6];
        if (start && m_mode[2:0] == 3'd0) m_err = 1;
        if (ok) begin
          q_tx.delete();
          for (int i = 0; i < 8; i++) q_tx.push_back(m_mode[7] ? tx_byte[7-i] : tx_byte[i]);
          m_busy = 1; m_cnt = 0; m_edge = 0; m_act = m_mode;
          if (m_mode[5]) m_sdo = q_tx.pop_front();
        end
      end
      if (wr_en) m_mode = wr_data & 8'hE7;
    end
  end

  task automatic cmp(string req, string nm, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, nm, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      cycles++;
      cmp("R1", "mode_rd", mode_rd, m_mode);
      cmp("R3", "sclk", {7'd0, sclk}, {7'd0, m_sclk});
      cmp("R4", "sdo", {7'd0, sdo}, {7'd0, m_sdo});
      cmp("R2", "busy", {7'd0, busy}, {7'd0, m_busy});
      cmp("R10", "done", {7'd0, done}, {7'd0, m_done});
      cmp("R7", "err", {7'd0, err}, {7'd0, m_err});
      if (m_done) cmp("R6", "rx_byte", rx_byte, m_rx);
      sdi <= 1'($urandom_range(0, 1));
    end
  end

  task automatic wr_mode(logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic go(logic [7:0] v);
    @(negedge clk); start = 1; tx_byte = v;
    @(negedge clk); start = 0;
  endtask

  task automatic settle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);             // R1 reset state
    wr_mode(8'hFF); repeat (2) @(negedge clk); // R1 reserved bits
    wr_mode(8'h81); go(8'hA5); settle();   // R4 R6 msb, phase 0
    wr_mode(8'h01); go(8'h3C); settle();   // R6 lsb first
    wr_mode(8'hC2); go(8'h96); settle();   // R3 idle low, R2 rate 2
    wr_mode(8'hE1); go(8'h5A); settle();   // R5 phase 1
    wr_mode(8'h23); go(8'hC3); settle();   // R5 lsb, rate 3
    wr_mode(8'hA1); go(8'h81); settle();   // R5 idle high
    wr_mode(8'h80); go(8'h77); settle();   // R7 reserved rate
    wr_mode(8'h87); go(8'h69); settle();   // R2 slowest rate
    wr_mode(8'h82); go(8'h12);             // R8 start while busy
    repeat (5) @(negedge clk); go(8'hED); settle();
    wr_mode(8'h81); go(8'hF0);             // R9 write mid-frame
    wr_mode(8'h63); settle(); go(8'h0F); settle();
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (running) begin
      running = 0;
      vectors++; misses++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule